// File: doc/BRIEF.md
# Dual-Rail Thermal Warning Monitor

The block watches two digitized thermistor readings, one per regulator rail. Each reading arrives as an unsigned millivolt code, and both share one valid strobe. A lower voltage means a hotter board. When either rail reaches the warning level, the block pulls an active-low hot alert. That alert stays asserted, behind a hysteresis band, until both rails have climbed clearly above the warning level.

A shared up/down integrator gives the fault path its minimum delay. The integrator climbs on each strobe while either rail sits at or below the warning level, and it falls on each strobe while both rails are above it. A short recovery therefore pushes the fault further out in time instead of cancelling it.

A thermal fault is latched when a rail is at or below the shutdown level and the integrator has reached its terminal count. The fault stays latched until the fault manager pulses a synchronous clear. The thresholds and the terminal count are parameters; the count is given in clock-free sample strobes, and by default 5000 strobes make 100 µs at 50 MHz.

Top module: `thermal_guard`

## Requirements
- R1: After reset, `hot_n` is 1, `therm_fault` is 0, and the integrator holds 0.
- R2: While the alert is released, a strobed sample with either channel code at or below TRIP_MV (640) drives `hot_n` to 0 on the cycle after the strobe.
- R3: While the alert is asserted, the release level is TRIP_MV+HYST_MV (660). A channel code in the range 641..660 keeps the alert asserted.
- R4: The alert is released, with `hot_n` going to 1 on the cycle after the strobe, only when a strobed sample has both channel codes strictly above 660.
- R5: On each strobe the integrator counts up by one if either channel is at or below 640, and down by one otherwise. It saturates at 0 and at TERM_CNT.
- R6: On a strobe where either channel is at or below SHUT_MV (580) and the integrator already equals TERM_CNT, `therm_fault` rises on the next cycle.
- R7: `therm_fault` stays latched until `fault_clr` is 1 at a clock edge, which clears it on the next cycle. The clear wins over a new fault in the same cycle.
- R8: Without a strobe, sample values have no effect: `hot_n`, `therm_fault` and the integrator keep their values.
- R9: After a release, the trip level returns to 640. A strobed code of 641..660 on both channels does not re-assert the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Strobe qualifying both sample codes |
| mv_a | input | CODE_W | Channel A thermistor voltage in mV |
| mv_b | input | CODE_W | Channel B thermistor voltage in mV |
| fault_clr | input | 1 | Synchronous clear of the latched fault |
| hot_n | output | 1 | Active-low hot alert |
| therm_fault | output | 1 | Latched thermal fault |

## Verification
The hardest state to reach is an integrator that is partly charged, then partly drained by a recovery, and then charged again. In that state the fault instant depends on the whole history of strobes, not only on the last excursion. The stimulus builds this with slow ramps that cross the warning band. Each ramp is broken up by recovery segments and by cycles without a strobe. The bench keeps an arithmetic model of the integrator, so the exact strobe on which the fault must appear is known.

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int CODE_W   = 12,
  parameter int TRIP_MV  = 640,
  parameter int HYST_MV  = 20,
  parameter int SHUT_MV  = 580,
  parameter int TERM_CNT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] mv_a,
  input  logic [CODE_W-1:0] mv_b,
  input  logic              fault_clr,
  output logic              hot_n,
  output logic              therm_fault
);
  localparam int CNT_W = $clog2(TERM_CNT + 1);
  localparam logic [CODE_W-1:0] TRIP_C = CODE_W'(TRIP_MV);
  localparam logic [CODE_W-1:0] REL_C  = CODE_W'(TRIP_MV + HYST_MV);
  localparam logic [CODE_W-1:0] SHUT_C = CODE_W'(SHUT_MV);
  localparam logic [CNT_W-1:0]  TERM_C = CNT_W'(TERM_CNT);

  logic             hot_q, fault_q;
  logic [CNT_W-1:0] dwell_q;

  wire warm   = (mv_a <= TRIP_C) || (mv_b <= TRIP_C);
  wire cool   = (mv_a >  REL_C)  && (mv_b >  REL_C);
  wire severe = (mv_a <= SHUT_C) || (mv_b <= SHUT_C);
  wire at_top = (dwell_q == TERM_C);
  wire at_bot = (dwell_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
    end else if (smp_vld) begin
      if (!hot_q && warm)
        hot_q <= 1'b1;
      else if (hot_q && cool)
        hot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
    end else if (smp_vld) begin
      if (warm && !at_top)
        dwell_q <= dwell_q + 1'b1;
      else if (!warm && !at_bot)
        dwell_q <= dwell_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fault_q <= 1'b0;
    else if (fault_clr)
      fault_q <= 1'b0;
    else if (smp_vld && severe && at_top)
      fault_q <= 1'b1;
  end

  assign hot_n       = ~hot_q;
  assign therm_fault = fault_q;
endmodule

module thermal_guard_chk #(
  parameter int CODE_W   = 12,
  parameter int TRIP_MV  = 640,
  parameter int HYST_MV  = 20,
  parameter int SHUT_MV  = 580,
  parameter int TERM_CNT = 5000,
  parameter int CNT_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic [CODE_W-1:0] mv_a,
  input logic [CODE_W-1:0] mv_b,
  input logic              fault_clr,
  input logic              hot_n,
  input logic              therm_fault,
  input logic [CNT_W-1:0]  dwell
);
  // R2
  trip_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (int'(mv_a) <= TRIP_MV || int'(mv_b) <= TRIP_MV)) |=> !hot_n);
  // R4
  release_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_n) |-> ($past(smp_vld) && int'($past(mv_a)) > TRIP_MV + HYST_MV
                      && int'($past(mv_b)) > TRIP_MV + HYST_MV));
  // R5
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dwell) <= TERM_CNT);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(hot_n) && $stable(dwell)));
  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_fault) |-> ($past(smp_vld) && int'($past(dwell)) == TERM_CNT &&
      (int'($past(mv_a)) <= SHUT_MV || int'($past(mv_b)) <= SHUT_MV)));
  // R7
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !therm_fault);
  // R7
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_fault && !fault_clr) |=> therm_fault);
endmodule

bind thermal_guard thermal_guard_chk #(
  .CODE_W(CODE_W), .TRIP_MV(TRIP_MV), .HYST_MV(HYST_MV),
  .SHUT_MV(SHUT_MV), .TERM_CNT(TERM_CNT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .mv_a(mv_a), .mv_b(mv_b),
  .fault_clr(fault_clr), .hot_n(hot_n), .therm_fault(therm_fault),
  .dwell(dwell_q)
);

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb;
  localparam int W = 12;
  localparam int TERM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic clr = 1'b0;
  logic [W-1:0] a = W'(700);
  logic [W-1:0] b = W'(700);
  logic hot_n, flt;

  int checks = 0;
  int fails = 0;
  int m_hot = 0;
  int m_cnt = 0;
  int m_flt = 0;

  always #10 clk = ~clk;

  thermal_guard #(.CODE_W(W), .TERM_CNT(TERM)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(vld), .mv_a(a), .mv_b(b),
    .fault_clr(clr), .hot_n(hot_n), .therm_fault(flt));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int va, input int vb, input bit v, input bit c);
    int w;
    a = W'(va); b = W'(vb); vld = v; clr = c;
    @(negedge clk);
    w = (va <= 640 || vb <= 640) ? 1 : 0;
    if (c) m_flt = 0;
    else if (v && (va <= 580 || vb <= 580) && m_cnt == TERM) m_flt = 1;
    if (v) begin
      if (m_hot == 0 && w == 1) m_hot = 1;
      else if (m_hot == 1 && va > 660 && vb > 660) m_hot = 0;
      if (w == 1 && m_cnt < TERM) m_cnt++;
      else if (w == 0 && m_cnt > 0) m_cnt--;
    end
    vld = 1'b0; clr = 1'b0;
    check("R2 R3 R4 hot_n", int'(hot_n), 1 - m_hot);
    check("R5 R6 R7 fault", int'(flt), m_flt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hot_n", int'(hot_n), 1);
    check("R1 fault", int'(flt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(700, 700, 1, 0);
    // R9: band between trip and release does not trip a released alert
    step(650, 660, 1, 0);
    check("R9 no retrip", int'(hot_n), 1);
    // slow ramps on channel A, then B, then both, with idle gaps (R8)
    for (int ch = 0; ch < 3; ch++) begin
      for (int mv = 700; mv >= 560; mv -= 4) begin
        step(ch != 1 ? mv : 700, ch != 0 ? mv : 700, 1, 0);
        if (mv % 12 == 0) step(300, 300, 0, 0);
      end
      for (int mv = 560; mv <= 704; mv += 4)
        step(ch != 1 ? mv : 700, ch != 0 ? mv : 700, 1, 0);
      step(700, 700, 0, 1);
      for (int k = 0; k < TERM + 1; k++) step(700, 700, 1, 0);
    end
    // R3: hysteresis band keeps alert asserted
    step(640, 700, 1, 0);
    check("R2 trip at 640", int'(hot_n), 0);
    step(660, 700, 1, 0);
    check("R3 hold at 660", int'(hot_n), 0);
    // R4: one channel cool is not enough
    step(700, 655, 1, 0);
    check("R4 one channel", int'(hot_n), 0);
    step(661, 661, 1, 0);
    check("R4 both released", int'(hot_n), 1);
    for (int k = 0; k < TERM; k++) step(700, 700, 1, 0);
    // R5: partial charge, partial drain, then charge to fault
    for (int k = 0; k < 4; k++) step(630, 700, 1, 0);
    for (int k = 0; k < 2; k++) step(700, 700, 1, 0);
    for (int k = 0; k < 3; k++) step(700, 575, 1, 0);
    check("R5 extended no fault", int'(flt), 0);
    step(700, 575, 1, 0);
    check("R5 at top no fault yet", int'(flt), 0);
    step(700, 575, 1, 0);
    check("R6 fault after terminal", int'(flt), 1);
    // R8: no strobe, severe values ignored
    step(100, 100, 0, 0);
    check("R8 idle fault held", int'(flt), 1);
    // R7: clear beats a new fault
    step(570, 570, 1, 1);
    check("R7 clear priority", int'(flt), 0);
    step(570, 570, 1, 0);
    check("R6 refault", int'(flt), 1);
    step(700, 700, 0, 0);
    check("R7 latched", int'(flt), 1);
    step(700, 700, 0, 1);
    check("R7 cleared", int'(flt), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule